// File: doc/BRIEF.md
# Host Wake and Power Sequencer

This block manages the joint power states of a low-power transmitter and the small host controller attached to it, using only two shared bidirectional pins. The first pin carries the host clock when the block drives it. When the block leaves it undriven, a pull-up holds it high, and a push button can pull it low to start the system. The second pin holds the host in reset when driven low and releases it with a short high pulse. After that it becomes an input, and the host pulls it low to ask for shutdown.

In standby no clock runs anywhere. A button press on the clock pin arms a wake flag that needs no clock. The sequencer then enables the crystal oscillator and waits for it to report ready. It drives a divided host clock (crystal divided by 4 or by 6) and holds the host in reset for a fixed number of host periods. It then raises the reset pin for a second fixed number of periods and hands the pin over to the host. On a filtered stop request it waits a few more host periods and parks the host. It returns to standby at once in continuous mode. In single-message mode it keeps the oscillator on until the encoder reports that the transmission sequence is complete.

Top module: `host_power_seq`

## Requirements
- R1: In standby (the state after reset), osc_en is 0, the reset pin is driven low (rst_pin_oe=1, rst_pin_out=0) with its pull-up off (rst_pull_en=0), and the clock pin is undriven (clk_pin_oe=0) with its pull-up on (clk_pull_en=1).
- R2: A falling edge on the clock pin while in standby sets osc_en=1 within 5 clock cycles. The clock pin stays undriven until osc_ready is 1.
- R3: The cycle after osc_ready is seen, the clock pin is driven. The reset pin stays driven low for exactly 32 host periods (32 x ratio crystal cycles).
- R4: The reset pin is then driven high for exactly 16 host periods. After that it is released (rst_pin_oe=0) with rst_pull_en=1, and the block is active.
- R5: In the active state, a low on the reset pin is accepted as a stop only when it is seen on two consecutive host-period ticks after a two-flop synchronizer. A low lasting one crystal cycle leaves the block active.
- R6: Four host periods after a stop is accepted, the clock pin is released and the reset pin is driven low. Measured in crystal clock edges from the host pulling the pin low, this happens between 5 x ratio + 3 and 6 x ratio + 2 edges.
- R7: With single_mode=0, osc_en falls in the same cycle that the clock pin is released.
- R8: With single_mode=1, osc_en stays 1 after the host is parked until tx_done is 1. It falls on the next cycle, and the block is back in standby.
- R9: The host clock has a period of 4 crystal cycles when xtal_sel=0 and 6 when xtal_sel=1. Each period is high for the first half and low for the second half (2/2 or 3/3).
- R10: A change of xtal_sel takes effect only at a host period boundary. Every high phase is followed by a low phase of the same length, either 2 or 3 cycles.
- R11: A falling edge on the clock pin outside standby is ignored. After the block returns to standby it stays there (osc_en=0) without a new press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock (valid while the oscillator runs) |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_pin_in | input | 1 | Level sensed on the shared host-clock / start pin |
| rst_pin_in | input | 1 | Level sensed on the shared host-reset / stop pin |
| osc_ready | input | 1 | Oscillator has started and is stable |
| xtal_sel | input | 1 | Crystal select: 0 divides by 4, 1 divides by 6 |
| single_mode | input | 1 | 1 = single-message transmission, 0 = continuous |
| tx_done | input | 1 | Encoder has finished the transmission sequence |
| osc_en | output | 1 | Oscillator enable |
| clk_pin_oe | output | 1 | Output enable for the host-clock pin |
| clk_pin_out | output | 1 | Divided host clock driven on the host-clock pin |
| clk_pull_en | output | 1 | Pull-up enable for the host-clock pin |
| rst_pin_oe | output | 1 | Output enable for the host-reset pin |
| rst_pin_out | output | 1 | Level driven on the host-reset pin |
| rst_pull_en | output | 1 | Pull-up enable for the host-reset pin |

## Verification
The assertions assume that osc_ready and tx_done are synchronous to clk, and that single_mode is stable around the moment the stop delay ends. The bench changes every input at the falling edge of the clock, away from the sampling edge. The two pin inputs are resolved in the bench from the block's own enables, a modelled button and a modelled host driver, so the pins never see a contention the assertions do not allow for. The bench keeps xtal_sel fixed through each power-up and stop phase whose length it counts. It toggles xtal_sel only in one dedicated window while the block is active.

// File: rtl/hps_pkg.sv
// Shared types of the host wake and power sequencer.
package hps_pkg;
    typedef enum logic [2:0] {
        ST_STANDBY,     // clock-free standby, host held in reset
        ST_OSC_WAIT,    // oscillator enabled, waiting for ready
        ST_HOST_RST,    // clock running, host still in reset
        ST_WAKE_PULSE,  // reset pin driven high
        ST_ACTIVE,      // reset pin is a stop input
        ST_STOP_WAIT,   // stop accepted, counting down
        ST_DRAIN        // host parked, waiting for transmission end
    } hps_state_e;
endpackage

// File: rtl/host_clk_div.sv
// Host clock divider.
// Divides the crystal clock by LO_DIV or HI_DIV with a 50% duty cycle.
// The selection is latched only at a period boundary, or while stopped.
// Assumes both divide ratios are even and at least 2.
module host_clk_div #(
    parameter int LO_DIV = 4,
    parameter int HI_DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_hi,
    output logic clk_o,
    output logic tick
);
    localparam int CW = $clog2(HI_DIV);
    localparam logic [CW-1:0] LAST_LO = CW'(LO_DIV - 1);
    localparam logic [CW-1:0] LAST_HI = CW'(HI_DIV - 1);
    localparam logic [CW-1:0] HALF_LO = CW'(LO_DIV / 2);
    localparam logic [CW-1:0] HALF_HI = CW'(HI_DIV / 2);

    logic [CW-1:0] cnt_q;
    logic          sel_q;
    logic [CW-1:0] last_c;
    logic [CW-1:0] half_c;

    assign last_c = sel_q ? LAST_HI : LAST_LO;
    assign half_c = sel_q ? HALF_HI : HALF_LO;

    // Phase counter; reloads the ratio select at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            sel_q <= sel_hi;
        end else if (cnt_q == last_c) begin
            cnt_q <= '0;
            sel_q <= sel_hi;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // High for the first half of the period, low for the second half.
    assign clk_o = run && (cnt_q < half_c);
    assign tick  = run && (cnt_q == last_c);

    // R10: the ratio may only change where a period has just ended.
    a_r10_ratio_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && cnt_q != '0) |-> $stable(sel_q));
endmodule

// File: rtl/hps_wake_latch.sv
// Start-edge detector.
// A flag is set by a falling edge on the clock pin without any running clock.
// It is cleared asynchronously while clr_req (registered) is high and is
// brought into the clock domain through two flops.
// Assumes the clock pin only falls from a button while it is undriven.
module hps_wake_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic clr_req,
    output logic seen
);
    logic clr_q;
    logic flag_q;
    logic [1:0] sync_q;

    // Registered clear: held during reset and outside standby.
    always_ff @(posedge clk) begin
        clr_q <= !rst_n || clr_req;
    end

    // Clock-free wake flag, armed by a falling pin edge.
    always_ff @(negedge pin_in or posedge clr_q) begin
        if (clr_q) flag_q <= 1'b0;
        else       flag_q <= 1'b1;
    end

    // Two-flop synchronizer into the crystal domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], flag_q};
    end

    assign seen = sync_q[1];
endmodule

// File: rtl/hps_stop_filter.sv
// Stop request filter.
// Synchronizes the reset/stop pin and accepts a stop only after the pin
// reads low on LOW_TICKS consecutive host-period ticks while enabled.
// Assumes tick pulses for one cycle per host period.
module hps_stop_filter #(
    parameter int LOW_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic pin_in,
    output logic accept
);
    localparam int LW = $clog2(LOW_TICKS + 1);
    localparam logic [LW-1:0] LOW_LAST = LW'(LOW_TICKS - 1);

    logic [1:0]    sync_q;
    logic [LW-1:0] low_q;
    logic          pin_low;

    // Two-flop synchronizer for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], pin_in};
    end

    assign pin_low = !sync_q[1];

    // Counts consecutive ticks on which the pin reads low.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            low_q <= '0;
        end else if (tick) begin
            if (!pin_low)             low_q <= '0;
            else if (low_q != LOW_LAST) low_q <= low_q + 1'b1;
        end
    end

    assign accept = en && tick && pin_low && (low_q == LOW_LAST);

    // R5: an accepted stop always follows a low-reading tick.
    a_r5_accept_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(!sync_q[0]));
endmodule

// File: rtl/host_power_seq.sv
// Host wake and power sequencer (top).
// Wakes from a clock-free standby on a button edge on the clock pin, runs
// the oscillator, supplies the divided host clock, times the host reset
// release, waits for the host stop request and parks everything again.
// In single-message mode the oscillator is held until tx_done.
// Assumes osc_ready and tx_done are synchronous to clk.
module host_power_seq
    import hps_pkg::*;
#(
    parameter int LO_DIV     = 4,
    parameter int HI_DIV     = 6,
    parameter int RST_PER    = 32,
    parameter int PULSE_PER  = 16,
    parameter int STOP_PER   = 4,
    parameter int STOP_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_pin_in,
    input  logic rst_pin_in,
    input  logic osc_ready,
    input  logic xtal_sel,
    input  logic single_mode,
    input  logic tx_done,
    output logic osc_en,
    output logic clk_pin_oe,
    output logic clk_pin_out,
    output logic clk_pull_en,
    output logic rst_pin_oe,
    output logic rst_pin_out,
    output logic rst_pull_en
);
    localparam int MAX_A = (RST_PER > PULSE_PER) ? RST_PER : PULSE_PER;
    localparam int MAX_P = (MAX_A > STOP_PER) ? MAX_A : STOP_PER;
    localparam int SCW   = $clog2(MAX_P + 1);
    localparam logic [SCW-1:0] RST_LAST   = SCW'(RST_PER - 1);
    localparam logic [SCW-1:0] PULSE_LAST = SCW'(PULSE_PER - 1);
    localparam logic [SCW-1:0] STOP_LAST  = SCW'(STOP_PER - 1);

    hps_state_e     state_q, state_d;
    logic [SCW-1:0] per_q, per_d;
    logic           tick, div_clk, wake_seen, stop_ok;
    logic           clk_run, host_sense;

    assign clk_run    = (state_q == ST_HOST_RST) || (state_q == ST_WAKE_PULSE)
                     || (state_q == ST_ACTIVE)   || (state_q == ST_STOP_WAIT);
    assign host_sense = (state_q == ST_ACTIVE) || (state_q == ST_STOP_WAIT);

    hps_wake_latch u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (clk_pin_in),
        .clr_req (state_q != ST_STANDBY),
        .seen    (wake_seen)
    );

    host_clk_div #(.LO_DIV(LO_DIV), .HI_DIV(HI_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (clk_run),
        .sel_hi (xtal_sel),
        .clk_o  (div_clk),
        .tick   (tick)
    );

    hps_stop_filter #(.LOW_TICKS(STOP_TICKS)) u_stop (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state_q == ST_ACTIVE),
        .tick   (tick),
        .pin_in (rst_pin_in),
        .accept (stop_ok)
    );

    // Next-state and host-period counting.
    always_comb begin
        state_d = state_q;
        per_d   = per_q;
        case (state_q)
            ST_STANDBY: begin
                per_d = '0;
                if (wake_seen) state_d = ST_OSC_WAIT;
            end
            ST_OSC_WAIT: if (osc_ready) state_d = ST_HOST_RST;
            ST_HOST_RST: if (tick) begin
                if (per_q == RST_LAST) begin
                    per_d   = '0;
                    state_d = ST_WAKE_PULSE;
                end else begin
                    per_d = per_q + 1'b1;
                end
            end
            ST_WAKE_PULSE: if (tick) begin
                if (per_q == PULSE_LAST) begin
                    per_d   = '0;
                    state_d = ST_ACTIVE;
                end else begin
                    per_d = per_q + 1'b1;
                end
            end
            ST_ACTIVE: if (stop_ok) begin
                per_d   = '0;
                state_d = ST_STOP_WAIT;
            end
            ST_STOP_WAIT: if (tick) begin
                if (per_q == STOP_LAST) begin
                    per_d   = '0;
                    state_d = (single_mode && !tx_done) ? ST_DRAIN : ST_STANDBY;
                end else begin
                    per_d = per_q + 1'b1;
                end
            end
            ST_DRAIN: if (tx_done) state_d = ST_STANDBY;
            default: state_d = ST_STANDBY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
            per_q   <= '0;
        end else begin
            state_q <= state_d;
            per_q   <= per_d;
        end
    end

    // Pin and oscillator controls, decoded from state.
    assign osc_en      = (state_q != ST_STANDBY);
    assign clk_pin_oe  = clk_run;
    assign clk_pin_out = div_clk;
    assign clk_pull_en = !clk_run;
    assign rst_pin_oe  = !host_sense;
    assign rst_pin_out = (state_q == ST_WAKE_PULSE);
    assign rst_pull_en = host_sense;

    // R1: without the oscillator, the host is parked and the clock pin idle.
    a_r1_standby_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (rst_pin_oe && !rst_pin_out && !rst_pull_en && !clk_pin_oe && clk_pull_en));
    // R3: the reset pin is only raised while the host has a clock.
    a_r3_pulse_with_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pin_oe && rst_pin_out) |-> (clk_pin_oe && osc_en));
    // R6: releasing the clock pin parks the host in reset.
    a_r6_park_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_pin_oe) |-> (rst_pin_oe && !rst_pin_out));
    // R7: continuous mode drops the oscillator with the clock pin.
    a_r7_cont_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clk_pin_oe) && !$past(single_mode)) |-> !osc_en);
    // R8: single mode keeps the oscillator until the encoder is done.
    a_r8_single_osc_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clk_pin_oe) && $past(single_mode) && !$past(tx_done)) |-> osc_en);
endmodule

// File: tb/host_power_seq_test.sv
module host_power_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_ready = 1'b0, xtal_sel = 1'b0, single_mode = 1'b0, tx_done = 1'b0;
    logic btn = 1'b0, host_low = 1'b0;
    logic clk_pin_in, rst_pin_in;
    logic osc_en, clk_pin_oe, clk_pin_out, clk_pull_en;
    logic rst_pin_oe, rst_pin_out, rst_pull_en;

    int checks = 0, fails = 0;
    int exp_half = 0;
    bit mon_on = 1'b0;
    int hl = 0, ll = 0;

    always #2.5 clk = ~clk;

    // Pin resolution: block drive wins, else button / host, else pull-up.
    assign clk_pin_in = clk_pin_oe ? clk_pin_out : !btn;
    assign rst_pin_in = rst_pin_oe ? rst_pin_out : !host_low;

    host_power_seq uut (
        .clk(clk), .rst_n(rst_n), .clk_pin_in(clk_pin_in), .rst_pin_in(rst_pin_in),
        .osc_ready(osc_ready), .xtal_sel(xtal_sel), .single_mode(single_mode),
        .tx_done(tx_done), .osc_en(osc_en), .clk_pin_oe(clk_pin_oe),
        .clk_pin_out(clk_pin_out), .clk_pull_en(clk_pull_en), .rst_pin_oe(rst_pin_oe),
        .rst_pin_out(rst_pin_out), .rst_pull_en(rst_pull_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_standby(input string tag);
        chk(osc_en == 1'b0, {tag, " R1 osc_en"}, osc_en, 0);
        chk(rst_pin_oe && !rst_pin_out && !rst_pull_en, {tag, " R1 rst pin"},
            {rst_pin_oe, rst_pin_out, rst_pull_en}, 3'b100);
        chk(!clk_pin_oe && clk_pull_en, {tag, " R1 clk pin"}, {clk_pin_oe, clk_pull_en}, 2'b01);
    endtask

    // Host clock phase monitor (R9, R10).
    always @(negedge clk) begin
        if (mon_on) begin
            if (!clk_pin_oe) begin
                hl = 0; ll = 0;
            end else if (clk_pin_out) begin
                if (ll > 0) begin
                    chk(hl == ll && (hl == 2 || hl == 3), "R10 phase pair", hl, ll);
                    if (exp_half != 0) chk(hl == exp_half, "R9 half period", hl, exp_half);
                    hl = 0; ll = 0;
                end
                hl++;
            end else begin
                ll++;
            end
        end
    end

    task automatic run_seq(input bit sel, input bit single, input bit do_switch);
        int r = sel ? 6 : 4;
        int n;
        xtal_sel = sel; single_mode = single; tx_done = 1'b0; osc_ready = 1'b0;
        exp_half = r / 2;
        chk_standby("pre-wake");
        // R2: button press wakes the oscillator.
        btn = 1'b1;
        repeat (5) @(negedge clk);
        chk(osc_en == 1'b1, "R2 osc_en after press", osc_en, 1);
        btn = 1'b0;
        repeat (3) @(negedge clk);
        chk(clk_pin_oe == 1'b0, "R2 clock pin idle before ready", clk_pin_oe, 0);
        osc_ready = 1'b1;
        @(negedge clk);
        chk(clk_pin_oe == 1'b1, "R3 clock pin driven", clk_pin_oe, 1);
        // R3: reset hold length.
        n = 0;
        while (rst_pin_oe && !rst_pin_out && n < 5000) begin n++; @(negedge clk); end
        chk(n == 32 * r, "R3 reset hold cycles", n, 32 * r);
        // R4: release pulse length.
        n = 0;
        while (rst_pin_oe && rst_pin_out && n < 5000) begin n++; @(negedge clk); end
        chk(n == 16 * r, "R4 pulse cycles", n, 16 * r);
        chk(!rst_pin_oe && rst_pull_en, "R4 released with pull-up",
            {rst_pin_oe, rst_pull_en}, 2'b01);
        // R5: one-cycle glitch is ignored.
        repeat (7) @(negedge clk);
        host_low = 1'b1;
        @(negedge clk);
        host_low = 1'b0;
        repeat (40) @(negedge clk);
        chk(!rst_pin_oe && clk_pin_oe, "R5 glitch ignored", {rst_pin_oe, clk_pin_oe}, 2'b01);
        if (do_switch) begin
            exp_half = 0;
            for (int k = 0; k < 8; k++) begin
                xtal_sel = ~xtal_sel;
                repeat (k + 3) @(negedge clk);
            end
            xtal_sel = sel;
            repeat (20) @(negedge clk);
            exp_half = r / 2;
        end
        // R6: stop request and park latency.
        host_low = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (clk_pin_oe && n < 5000);
        chk(n >= 5 * r + 3 && n <= 6 * r + 2, "R6 stop latency", n, 5 * r + 3);
        chk(rst_pin_oe && !rst_pin_out, "R6 host parked", {rst_pin_oe, rst_pin_out}, 2'b10);
        host_low = 1'b0;
        if (!single) begin
            chk(osc_en == 1'b0, "R7 continuous osc off", osc_en, 0);
        end else begin
            chk(osc_en == 1'b1, "R8 osc held after park", osc_en, 1);
            // R11: press during drain is ignored.
            btn = 1'b1;
            repeat (3) @(negedge clk);
            btn = 1'b0;
            repeat (7) @(negedge clk);
            chk(osc_en == 1'b1, "R8 osc still held", osc_en, 1);
            tx_done = 1'b1;
            @(negedge clk);
            chk(osc_en == 1'b0, "R8 osc off after tx_done", osc_en, 0);
            tx_done = 1'b0;
            repeat (20) @(negedge clk);
            chk(osc_en == 1'b0, "R11 no restart from ignored press", osc_en, 0);
        end
        osc_ready = 1'b0;
        chk_standby("post-stop");
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk_standby("reset");
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        chk_standby("after reset");
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 2; m++) begin
                run_seq(s[0], m[0], 1'b0);
            end
        end
        run_seq(1'b0, 1'b0, 1'b1);
        run_seq(1'b1, 1'b1, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule